// File: doc/BRIEF.md
# Remote Terminal Status Word and Error Flag Unit

This block forms the 16-bit status word that a serial-bus remote terminal returns after each command addressed to it. The word carries the terminal's own address, a message error bit, and five condition bits whose values come straight from host-side pins. The block also decides whether the terminal may move data words for the current message. A host pin that marks the command illegal, or a busy pin, withholds that permission. A parity fault on the terminal address strap silences the terminal completely.

Commands reach the block from the command decoder on a valid/ready stream (`cmd_valid`/`cmd_ready`). A command is taken on a cycle where both are high, and the host pins are sampled on that same cycle. Status words leave on a second valid/ready stream (`stat_valid`/`stat_ready`). Only one status word can be outstanding at a time, so `cmd_ready` stays low until the word has been taken. This is how back-pressure from the word encoder stalls the decoder. A separate active-low flag collects the decoder's error strobes for the host.

Top module: `rt_status_unit`

## Requirements
- R1: `addr_err_n` is low one cycle after the six lines `rt_addr[4:0]` and `rt_addr_par` carry an even number of ones, and high one cycle after they carry an odd number. Reset leaves it low until the first check.
- R2: A command taken while `addr_err_n` is low produces no status word, and `data_en` is low from the next cycle.
- R3: Status word layout: bits [15:11] hold the address sampled with the command, and bits 9, 7, 6 and 5 are always 0.
- R4: The host pins for service request, dynamic bus control acceptance, terminal flag and subsystem flag appear in bits 8, 1, 0 and 2 of the status word. They hold their values from the cycle the command was taken.
- R5: A command taken with `host_illegal` high still returns a status word, with bit 10 (message error) set, and `data_en` is low for that message. With `host_illegal` low, bit 10 is 0.
- R6: A command taken with `host_busy` high sets bit 3 (busy), and `data_en` is low for that message.
- R7: A command taken with good address parity, `host_illegal` low and `host_busy` low sets `data_en` high from the next cycle. It stays high until the next command is taken.
- R8: While `stat_valid` is high and `stat_ready` is low, `stat_valid` stays high, `stat_word` holds its value, and `cmd_ready` is low.
- R9: A command taken with `cmd_bcast` high returns no status word. Bit 4 of the next status word is set, and bit 4 of the word after that is clear.
- R10: `msg_err_n` goes low the cycle after any bit of `dec_err` is high. It returns high the cycle after a command is taken with no error strobe present. `dec_err` bits are: [0] format, [1] word count, [2] invalid word, [3] sync.
- R11: Changes on the host pins after a command is taken do not alter the status word already built.
- R12: After reset, `stat_valid` and `data_en` are low and `msg_err_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rt_addr | input | 5 | Terminal address strap |
| rt_addr_par | input | 1 | Address parity strap (odd over six lines) |
| host_srq | input | 1 | Service request bit source |
| host_dbca | input | 1 | Dynamic bus control acceptance bit source |
| host_tflag | input | 1 | Terminal flag bit source |
| host_busy | input | 1 | Busy bit source; withholds data transfer |
| host_ssf | input | 1 | Subsystem flag bit source |
| host_illegal | input | 1 | Marks the current command illegal |
| cmd_valid | input | 1 | Decoded command present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_bcast | input | 1 | Command is a broadcast |
| dec_err | input | N_ERR | Decoder error strobes |
| stat_valid | output | 1 | Status word available |
| stat_ready | input | 1 | Encoder takes the status word |
| stat_word | output | 16 | Status word, bit 15 sent first |
| data_en | output | 1 | Data words may be moved for this message |
| addr_err_n | output | 1 | Address parity fault, active low |
| msg_err_n | output | 1 | Message error flag, active low |

## Verification
The bench builds the block with its default N_ERR of 4. This lets it drive each of the four error strobes in turn and confirm that every one alone pulls the message error flag. The address width is held at five bits, so the bench can reach both all-ones and mixed address patterns. It can also force even parity by inverting the parity strap. Holding `stat_ready` low brings the stall path within reach, with the decoder blocked behind a pending word.

// File: rtl/rt_stat_pkg.sv
package rt_stat_pkg;
  localparam int RT_ADDR_W = 5;
  localparam int SW_W      = 16;

  typedef struct packed {
    logic srq;
    logic dbca;
    logic tflag;
    logic busy;
    logic ssf;
    logic illegal;
  } host_bits_t;

  function automatic logic [SW_W-1:0] build_word(
      input logic [RT_ADDR_W-1:0] addr,
      input host_bits_t           h,
      input logic                 bcr);
    logic [SW_W-1:0] w;
    w        = '0;
    w[15:11] = addr;
    w[10]    = h.illegal;
    w[8]     = h.srq;
    w[4]     = bcr;
    w[3]     = h.busy;
    w[2]     = h.ssf;
    w[1]     = h.dbca;
    w[0]     = h.tflag;
    return w;
  endfunction
endpackage

// File: rtl/rt_addr_chk.sv
module rt_addr_chk #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          par,
  output logic          fault_q
);
  logic odd_ok;
  assign odd_ok = ^{addr, par};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 1'b1;
    else        fault_q <= ~odd_ok;
  end
endmodule

// File: rtl/rt_stat_capture.sv
module rt_stat_capture
  import rt_stat_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire,
  input  logic                 fault,
  input  logic                 bcast,
  input  host_bits_t           host,
  input  logic [RT_ADDR_W-1:0] addr,
  input  logic                 stat_ready,
  output logic                 stat_valid,
  output logic [SW_W-1:0]      stat_word,
  output logic                 data_en
);
  logic bcr_q;
  logic respond;
  logic legal_xfer;

  assign respond    = fire && !fault && !bcast;
  assign legal_xfer = !fault && !host.illegal && !host.busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_valid <= 1'b0;
      stat_word  <= '0;
      data_en    <= 1'b0;
      bcr_q      <= 1'b0;
    end else begin
      if (fire) data_en <= legal_xfer;

      if (respond) begin
        stat_valid <= 1'b1;
        stat_word  <= build_word(addr, host, bcr_q);
        bcr_q      <= 1'b0;
      end else begin
        if (fire && !fault && bcast) bcr_q <= 1'b1;
        if (stat_valid && stat_ready) stat_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rt_err_flags.sv
module rt_err_flags #(
  parameter int N_ERR = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_ERR-1:0] err_stb,
  input  logic             fire,
  output logic             err_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         err_q <= 1'b0;
    else if (|err_stb)  err_q <= 1'b1;
    else if (fire)      err_q <= 1'b0;
  end
endmodule

// File: rtl/rt_status_unit.sv
module rt_status_unit
  import rt_stat_pkg::*;
#(
  parameter int N_ERR = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [RT_ADDR_W-1:0] rt_addr,
  input  logic                 rt_addr_par,
  input  logic                 host_srq,
  input  logic                 host_dbca,
  input  logic                 host_tflag,
  input  logic                 host_busy,
  input  logic                 host_ssf,
  input  logic                 host_illegal,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic                 cmd_bcast,
  input  logic [N_ERR-1:0]     dec_err,
  output logic                 stat_valid,
  input  logic                 stat_ready,
  output logic [SW_W-1:0]      stat_word,
  output logic                 data_en,
  output logic                 addr_err_n,
  output logic                 msg_err_n
);
  logic       fault_q;
  logic       fire;
  logic       err_q;
  host_bits_t host;

  assign host = '{srq: host_srq, dbca: host_dbca, tflag: host_tflag,
                  busy: host_busy, ssf: host_ssf, illegal: host_illegal};

  assign cmd_ready = !stat_valid;
  assign fire      = cmd_valid && cmd_ready;

  rt_addr_chk #(.AW(RT_ADDR_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (rt_addr),
    .par     (rt_addr_par),
    .fault_q (fault_q)
  );

  rt_stat_capture u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .fault      (fault_q),
    .bcast      (cmd_bcast),
    .host       (host),
    .addr       (rt_addr),
    .stat_ready (stat_ready),
    .stat_valid (stat_valid),
    .stat_word  (stat_word),
    .data_en    (data_en)
  );

  rt_err_flags #(.N_ERR(N_ERR)) u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .err_stb (dec_err),
    .fire    (fire),
    .err_q   (err_q)
  );

  assign addr_err_n = !fault_q;
  assign msg_err_n  = !err_q;
endmodule

// File: rtl/rt_status_unit_chk.sv
module rt_status_unit_chk
  import rt_stat_pkg::*;
#(
  parameter int N_ERR = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [RT_ADDR_W-1:0] rt_addr,
  input logic                 rt_addr_par,
  input logic                 host_srq,
  input logic                 host_dbca,
  input logic                 host_tflag,
  input logic                 host_busy,
  input logic                 host_ssf,
  input logic                 host_illegal,
  input logic                 cmd_valid,
  input logic                 cmd_ready,
  input logic                 cmd_bcast,
  input logic [N_ERR-1:0]     dec_err,
  input logic                 stat_valid,
  input logic                 stat_ready,
  input logic [SW_W-1:0]      stat_word,
  input logic                 data_en,
  input logic                 addr_err_n,
  input logic                 msg_err_n
);
  logic seen;
  logic fire;
  assign fire = cmd_valid && cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  a_r1_odd_parity: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (addr_err_n == $past(^{rt_addr, rt_addr_par})));

  a_r2_fault_silent: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !addr_err_n |=> !stat_valid && !data_en);

  a_r3_addr_field: assert property (@(posedge clk) disable iff (!rst_n)
    fire && addr_err_n && !cmd_bcast |=> stat_word[15:11] == $past(rt_addr));

  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> (stat_word[9] == 1'b0 && stat_word[7:5] == 3'b000));

  a_r5_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    fire && addr_err_n && host_illegal && !cmd_bcast |=>
      stat_valid && stat_word[10] && !data_en);

  a_r6_busy: assert property (@(posedge clk) disable iff (!rst_n)
    fire && addr_err_n && host_busy && !cmd_bcast |=>
      stat_valid && stat_word[3] && !data_en);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid && !stat_ready |=> stat_valid && $stable(stat_word));

  a_r8_block_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> !cmd_ready);

  a_r9_bcast_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    fire && addr_err_n && cmd_bcast |=> !stat_valid);

  a_r10_msg_err: assert property (@(posedge clk) disable iff (!rst_n)
    (|dec_err) |=> !msg_err_n);
endmodule

bind rt_status_unit rt_status_unit_chk #(.N_ERR(N_ERR)) u_chk (.*);

// File: tb/sim_rt_status_unit.sv
`timescale 1ns/1ps
module sim_rt_status_unit;
  localparam int N_ERR = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  rt_addr = 5'h0A;
  logic        rt_addr_par = 1'b1;
  logic        host_srq = 0, host_dbca = 0, host_tflag = 0, host_busy = 0;
  logic        host_ssf = 0, host_illegal = 0;
  logic        cmd_valid = 0, cmd_bcast = 0;
  logic        cmd_ready;
  logic [N_ERR-1:0] dec_err = '0;
  logic        stat_valid, stat_ready = 1'b1;
  logic [15:0] stat_word;
  logic        data_en, addr_err_n, msg_err_n;

  int checks = 0;
  int fails  = 0;
  logic [15:0] exp_q[$];
  logic        bcr_exp = 1'b0;
  bit          done = 0;

  always #4 clk = ~clk;

  rt_status_unit #(.N_ERR(N_ERR)) u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Scoreboard monitor: every transfer on the status stream is compared.
  always @(negedge clk) begin
    if (rst_n && stat_valid && stat_ready) begin
      if (exp_q.size() == 0) begin
        chk(0, "R9/R2 unexpected word", {16'h0, stat_word}, 32'h0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(stat_word == e, "R3/R4/R5/R6/R9/R11 word", {16'h0, stat_word}, {16'h0, e});
      end
    end
  end

  function automatic logic good_par(input logic [4:0] a);
    return ~^a;
  endfunction

  // Driver: push expected word, present command, wait for acceptance.
  task automatic send(input bit bc, input bit ill, input bit bsy, input bit srq,
                      input bit dbca, input bit tf, input bit ssf, input bit resp);
    host_illegal = ill; host_busy = bsy; host_srq = srq;
    host_dbca = dbca; host_tflag = tf; host_ssf = ssf; cmd_bcast = bc;
    if (resp && !bc) begin
      exp_q.push_back({rt_addr, ill, 1'b0, srq, 3'b000, bcr_exp, bsy, ssf, dbca, tf});
      bcr_exp = 1'b0;
    end else if (resp && bc) begin
      bcr_exp = 1'b1;
    end
    cmd_valid = 1'b1;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    cmd_bcast = 1'b0;
    // R11: scramble host pins right after capture
    host_illegal = ~ill; host_busy = ~bsy; host_srq = ~srq;
    host_dbca = ~dbca; host_tflag = ~tf; host_ssf = ~ssf;
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    chk(stat_valid == 0, "R12 stat_valid", stat_valid, 0);
    chk(data_en == 0, "R12 data_en", data_en, 0);
    chk(msg_err_n == 1, "R12 msg_err_n", msg_err_n, 1);
    chk(addr_err_n == 0, "R1 reset fault", addr_err_n, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    rt_addr = 5'h0A; rt_addr_par = good_par(5'h0A);
    repeat (2) @(posedge clk); #1;
    @(negedge clk);
    chk(addr_err_n == 1, "R1 odd parity ok", addr_err_n, 1);
    @(posedge clk); #1;

    // R7 legal command, R4 host bits
    send(0, 0, 0, 1, 0, 1, 0, 1);
    @(negedge clk);
    chk(data_en == 1, "R7 data_en legal", data_en, 1);

    // R5 illegal command
    @(posedge clk); #1;
    send(0, 1, 0, 0, 1, 0, 1, 1);
    @(negedge clk);
    chk(data_en == 0, "R5 data_en illegal", data_en, 0);

    // R6 busy
    @(posedge clk); #1;
    send(0, 0, 1, 1, 1, 1, 1, 1);
    @(negedge clk);
    chk(data_en == 0, "R6 data_en busy", data_en, 0);

    // R8 back-pressure
    @(posedge clk); #1;
    stat_ready = 1'b0;
    rt_addr = 5'h1F; rt_addr_par = good_par(5'h1F);
    repeat (2) @(posedge clk); #1;
    send(0, 0, 0, 0, 1, 1, 0, 1);
    @(negedge clk);
    begin
      logic [15:0] held;
      held = stat_word;
      repeat (4) begin
        @(posedge clk); #1;
        host_srq = ~host_srq; host_ssf = ~host_ssf;
      end
      @(negedge clk);
      chk(stat_valid == 1, "R8 valid held", stat_valid, 1);
      chk(cmd_ready == 0, "R8 cmd_ready low", cmd_ready, 0);
      chk(stat_word == held, "R8 word stable", stat_word, held);
    end
    @(posedge clk); #1 stat_ready = 1'b1;
    @(negedge clk);
    @(posedge clk); #1;

    // R9 broadcast
    send(1, 0, 0, 1, 0, 0, 0, 1);
    repeat (3) @(negedge clk);
    chk(stat_valid == 0, "R9 no word on broadcast", stat_valid, 0);
    @(posedge clk); #1;
    send(0, 0, 0, 0, 0, 0, 1, 1);
    @(negedge clk);
    @(posedge clk); #1;
    send(0, 0, 0, 1, 1, 0, 0, 1);
    @(negedge clk);

    // R1/R2 address fault
    @(posedge clk); #1;
    rt_addr = 5'h05; rt_addr_par = ~good_par(5'h05);
    repeat (2) @(posedge clk); #1;
    @(negedge clk);
    chk(addr_err_n == 0, "R1 even parity fault", addr_err_n, 0);
    @(posedge clk); #1;
    send(0, 0, 0, 1, 1, 1, 1, 0);
    repeat (3) @(negedge clk);
    chk(stat_valid == 0, "R2 no word on fault", stat_valid, 0);
    chk(data_en == 0, "R2 data_en on fault", data_en, 0);
    @(posedge clk); #1;
    rt_addr_par = good_par(5'h05);
    repeat (2) @(posedge clk); #1;
    @(negedge clk);
    chk(addr_err_n == 1, "R1 fault cleared", addr_err_n, 1);

    // R10 each error strobe
    for (int i = 0; i < N_ERR; i++) begin
      @(posedge clk); #1;
      dec_err = N_ERR'(1) << i;
      @(posedge clk); #1;
      dec_err = '0;
      @(negedge clk);
      chk(msg_err_n == 0, "R10 flag set", msg_err_n, 0);
      repeat (3) @(negedge clk);
      chk(msg_err_n == 0, "R10 flag held", msg_err_n, 0);
      @(posedge clk); #1;
      send(0, 0, 0, 0, 0, 1, 0, 1);
      @(negedge clk);
      chk(msg_err_n == 1, "R10 flag cleared", msg_err_n, 1);
    end

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all words seen", exp_q.size(), 0);
    done = 1;
    finish_run();
  end
endmodule